// File: doc/BRIEF.md
# Exception Entry and Return Bus Sequencer

This block runs the memory bus of an 8-bit-data processor whose program counter is 32 bits wide while the processor enters or leaves an exception. An entry request comes in three kinds: reset, software break, or maskable interrupt. For an entry, the block saves the program counter as four bytes, followed by a status byte, onto a 256-byte stack page. It then reads a four-byte handler address from the top of the address space. A return request reverses the operation. The block restores the status byte and the four program-counter bytes from the stack.

The processor core starts the block with a one-cycle request and gives it the current program counter, stack pointer and status. While the block runs, it owns the address, write-enable and write-data lines. Memory is synchronous: read data for an address shown in one cycle arrives on the data-in bus in the next cycle. At the end of a sequence, the block asserts a one-cycle done pulse. In that same cycle it presents the new program counter, stack pointer and status, and the bus address already equals the new program counter.

Top module: `exc_sequencer`

## Requirements
- R1: While rst_n is low at a clock edge, the block returns to idle. After reset, done, busy and bus_we are 0, and pc_out, sp_out, status_out and bus_addr are all 0.
- R2: A request (req_kind 1 = break, 2 = interrupt) is accepted at an edge where the block is idle. From the next cycle on, the program counter is written most significant byte first, one write per cycle, at 0x100 + SP, then 0x100 + SP − 1, and so on. The 8-bit pointer wraps within the page.
- R3: In the cycle after the four program-counter writes, the status byte is written at the next lower stack address. For a break it is status_in with bits 4 and 5 set. For an interrupt it is status_in with bit 5 set and bit 4 cleared.
- R4: A break pushes the address two bytes past pc_in. An interrupt pushes pc_in unchanged.
- R5: After the status cycle, the handler address is read least significant byte first. Reset (req_kind 0) reads 0xFFFFFFF4–0xFFFFFFF7; break and interrupt read 0xFFFFFFFC–0xFFFFFFFF. One further read cycle then repeats the last vector address.
- R6: A reset entry goes through the same five stack cycles at the same addresses, but with bus_we low in each of them.
- R7: When an entry completes, pc_out is the assembled vector, sp_out is SP − 5 modulo 256, and status_out is status_in with bit 2 (interrupt disable) set.
- R8: A return (req_kind 3) first does a dummy read at 0x100 + SP. It then reads the status byte at SP + 1 and the program-counter bytes at SP + 2 to SP + 5, least significant first, then repeats the last address for one cycle. It ends with pc_out set to the popped address, status_out set to the popped byte, and sp_out set to SP + 5.
- R9: done is high for exactly one cycle, which is the 11th cycle after acceptance for an entry and the 8th for a return. In that cycle bus_addr equals the new pc_out. busy is high from the first cycle after acceptance through the done cycle. Once idle, bus_addr keeps the loaded program counter.
- R10: A request or any input change made while busy has no effect on the bus trace or on the results of the running sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle sequence request |
| req_kind | input | 2 | 0 reset, 1 break, 2 interrupt, 3 return |
| pc_in | input | 32 | Current program counter (break opcode address for a break) |
| sp_in | input | 8 | Current stack pointer |
| status_in | input | 8 | Current status byte |
| bus_addr | output | 32 | Memory address |
| bus_we | output | 1 | Memory write enable |
| bus_wdata | output | 8 | Memory write data |
| bus_rdata | input | 8 | Memory read data, valid one cycle after its address |
| pc_out | output | 32 | Program counter after the sequence |
| sp_out | output | 8 | Stack pointer after the sequence |
| status_out | output | 8 | Status byte after the sequence |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequence in progress |

## Verification
The assertions take for granted three things about the inputs. First, every two-bit request code is meaningful. Second, read data belongs to the address shown one cycle earlier. Third, the stack pointer given with a request is the live one; the block does not check it against earlier sequences. The bench keeps within these assumptions. Its memory model always answers with one cycle of latency. It raises requests only from the falling clock edge, and it makes its mid-sequence disturbances at a fixed point where the block is known to be busy. Random stack pointers, including values near 0x00 and 0xFF, exercise page wrap in both directions.

// File: rtl/exc_seq_pkg.sv
// Shared types for the exception sequencer.
// Assumes an 8-bit status byte with interrupt-disable at bit 2,
// break at bit 4 and an always-one bit at bit 5.
package exc_seq_pkg;

    typedef enum logic [1:0] {
        EK_RESET  = 2'd0,
        EK_BREAK  = 2'd1,
        EK_IRQ    = 2'd2,
        EK_RETURN = 2'd3
    } exc_kind_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DUMMY,
        ST_PUSH_PC,
        ST_PUSH_ST,
        ST_VEC,
        ST_POP_ST,
        ST_POP_PC,
        ST_HOLD,
        ST_DONE
    } seq_state_t;

    localparam logic [7:0] MASK_IRQ_DIS = 8'h04;
    localparam logic [7:0] MASK_BREAK   = 8'h10;
    localparam logic [7:0] MASK_ONE     = 8'h20;

endpackage

// File: rtl/exc_seq_ctrl.sv
// Sequence controller: walks entry (push PC, push status, read vector)
// or return (dummy read, pop status, pop PC) one bus cycle per clock.
// Assumes requests are only sampled while idle.
module exc_seq_ctrl
    import exc_seq_pkg::*;
#(
    parameter  int PC_BYTES = 4,
    localparam int IDX_W    = (PC_BYTES > 1) ? $clog2(PC_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  exc_kind_t        req_kind,
    output seq_state_t       state,
    output logic [IDX_W-1:0] idx,
    output exc_kind_t        kind_q,
    output logic             accept,
    output logic             sp_dec,
    output logic             sp_inc,
    output logic             rd_status,
    output logic             rd_pcbyte,
    output logic             done,
    output logic             busy
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PC_BYTES - 1);

    // Per-cycle strobes decoded from the current step.
    always_comb begin
        accept    = (state == ST_IDLE) && req_valid;
        sp_dec    = (state == ST_PUSH_PC) || (state == ST_PUSH_ST);
        sp_inc    = (state == ST_DUMMY) || (state == ST_POP_ST) ||
                    ((state == ST_POP_PC) && (idx != LAST_IDX));
        rd_status = (state == ST_POP_ST);
        rd_pcbyte = (state == ST_VEC) || (state == ST_POP_PC);
        done      = (state == ST_DONE);
        busy      = (state != ST_IDLE);
    end

    // Step register, byte index and latched request kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx    <= '0;
            kind_q <= EK_RESET;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        kind_q <= req_kind;
                        idx    <= '0;
                        state  <= (req_kind == EK_RETURN) ? ST_DUMMY : ST_PUSH_PC;
                    end
                end
                ST_PUSH_PC: begin
                    if (idx == LAST_IDX) begin
                        idx   <= '0;
                        state <= ST_PUSH_ST;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_PUSH_ST: begin
                    idx   <= '0;
                    state <= ST_VEC;
                end
                ST_VEC: begin
                    if (idx == LAST_IDX) state <= ST_HOLD;
                    else                 idx   <= idx + 1'b1;
                end
                ST_DUMMY:  state <= ST_POP_ST;
                ST_POP_ST: begin
                    idx   <= '0;
                    state <= ST_POP_PC;
                end
                ST_POP_PC: begin
                    if (idx == LAST_IDX) state <= ST_HOLD;
                    else                 idx   <= idx + 1'b1;
                end
                ST_HOLD:  state <= ST_DONE;
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                            // R9
    AST_KIND_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> (kind_q == $past(kind_q)));         // R10

endmodule

// File: rtl/exc_seq_stack.sv
// Stack pointer tracker: loads the pointer on acceptance, steps it down
// per push and up per pop, and forms the page address.
// Assumes dec and inc are never requested together.
module exc_seq_stack #(
    parameter int                ADDR_W     = 32,
    parameter int                SP_W       = 8,
    parameter logic [ADDR_W-1:0] STACK_BASE = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SP_W-1:0]   sp_in,
    input  logic              dec,
    input  logic              inc,
    output logic [SP_W-1:0]   sp_cur,
    output logic [ADDR_W-1:0] stk_addr
);

    // Stack pointer register with wrap inside the page.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp_cur <= '0;
        else if (load) sp_cur <= sp_in;
        else if (dec)  sp_cur <= sp_cur - 1'b1;
        else if (inc)  sp_cur <= sp_cur + 1'b1;
    end

    // Page-relative address of the current stack slot.
    always_comb stk_addr = STACK_BASE + ADDR_W'(sp_cur);

    AST_SP_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> (sp_cur == $past(sp_cur) - 1'b1));          // R2
    AST_SP_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (sp_cur == $past(sp_cur) + 1'b1));          // R8

endmodule

// File: rtl/exc_seq_collect.sv
// Read-data collector: one cycle after a status or address-byte read it
// stores the returned byte; address bytes arrive low first and shift in.
// Assumes memory returns data exactly one cycle after the address.
module exc_seq_collect #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_status,
    input  logic              rd_pcbyte,
    input  logic [7:0]        rdata,
    output logic [ADDR_W-1:0] pc_acc,
    output logic [7:0]        st_acc
);

    logic pend_st;
    logic pend_pc;

    // Remember which kind of read is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_st <= 1'b0;
            pend_pc <= 1'b0;
        end else begin
            pend_st <= rd_status;
            pend_pc <= rd_pcbyte;
        end
    end

    // Capture returned bytes into the status and address accumulators.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_acc <= '0;
            st_acc <= '0;
        end else begin
            if (pend_st) st_acc <= rdata;
            if (pend_pc) pc_acc <= {rdata, pc_acc[ADDR_W-1:8]};
        end
    end

    AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_status && rd_pcbyte));                                     // R8

endmodule

// File: rtl/exc_sequencer.sv
// Exception entry/return bus sequencer for an 8-bit-data core with a wide
// program counter. Latches the request frame, drives the bus per step and
// publishes the new PC, SP and status with a one-cycle done pulse.
// Assumes synchronous memory with one cycle of read latency.
module exc_sequencer
    import exc_seq_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter int                SP_W         = 8,
    parameter logic [ADDR_W-1:0] STACK_BASE   = 32'h0000_0100,
    parameter logic [ADDR_W-1:0] RESET_VECTOR = 32'hFFFF_FFF4,
    parameter logic [ADDR_W-1:0] IRQ_VECTOR   = 32'hFFFF_FFFC,
    parameter int                BREAK_LEN    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [SP_W-1:0]   sp_in,
    input  logic [7:0]        status_in,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    output logic [ADDR_W-1:0] pc_out,
    output logic [SP_W-1:0]   sp_out,
    output logic [7:0]        status_out,
    output logic              done,
    output logic              busy
);

    localparam int PC_BYTES = ADDR_W / 8;
    localparam int IDX_W    = (PC_BYTES > 1) ? $clog2(PC_BYTES) : 1;
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(PC_BYTES - 1);
    localparam logic [ADDR_W-1:0] STACK_TOP = STACK_BASE + ADDR_W'((1 << SP_W) - 1);

    seq_state_t        state;
    logic [IDX_W-1:0]  idx;
    exc_kind_t         kind_q;
    logic              accept, sp_dec, sp_inc, rd_status, rd_pcbyte;
    logic [SP_W-1:0]   sp_cur;
    logic [ADDR_W-1:0] stk_addr;
    logic [ADDR_W-1:0] pc_acc;
    logic [7:0]        st_acc;

    logic [ADDR_W-1:0] pc_push;
    logic [7:0]        st_push;
    logic [7:0]        st_entry;
    logic [ADDR_W-1:0] pc_q;
    logic [SP_W-1:0]   sp_q;
    logic [7:0]        st_q;
    logic [ADDR_W-1:0] vec_base;
    logic [IDX_W-1:0]  byte_sel;
    logic              stack_we;

    exc_seq_ctrl #(.PC_BYTES(PC_BYTES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (exc_kind_t'(req_kind)),
        .state     (state),
        .idx       (idx),
        .kind_q    (kind_q),
        .accept    (accept),
        .sp_dec    (sp_dec),
        .sp_inc    (sp_inc),
        .rd_status (rd_status),
        .rd_pcbyte (rd_pcbyte),
        .done      (done),
        .busy      (busy)
    );

    exc_seq_stack #(.ADDR_W(ADDR_W), .SP_W(SP_W), .STACK_BASE(STACK_BASE)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .sp_in    (sp_in),
        .dec      (sp_dec),
        .inc      (sp_inc),
        .sp_cur   (sp_cur),
        .stk_addr (stk_addr)
    );

    exc_seq_collect #(.ADDR_W(ADDR_W)) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_status (rd_status),
        .rd_pcbyte (rd_pcbyte),
        .rdata     (bus_rdata),
        .pc_acc    (pc_acc),
        .st_acc    (st_acc)
    );

    // Latch the values to push and the entry status at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_push  <= '0;
            st_push  <= '0;
            st_entry <= '0;
        end else if (accept) begin
            pc_push  <= (exc_kind_t'(req_kind) == EK_BREAK) ? pc_in + ADDR_W'(BREAK_LEN) : pc_in;
            st_push  <= (exc_kind_t'(req_kind) == EK_BREAK) ? (status_in | MASK_BREAK | MASK_ONE)
                                                            : ((status_in | MASK_ONE) & ~MASK_BREAK);
            st_entry <= status_in | MASK_IRQ_DIS;
        end
    end

    // Retain the results of the last completed sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            sp_q <= '0;
            st_q <= '0;
        end else if (done) begin
            pc_q <= pc_acc;
            sp_q <= sp_cur;
            st_q <= (kind_q == EK_RETURN) ? st_acc : st_entry;
        end
    end

    // Present results during the done cycle, held values otherwise.
    always_comb begin
        pc_out     = done ? pc_acc : pc_q;
        sp_out     = done ? sp_cur : sp_q;
        status_out = done ? ((kind_q == EK_RETURN) ? st_acc : st_entry) : st_q;
    end

    // Vector base, pushed byte select and write qualifier.
    always_comb begin
        vec_base = (kind_q == EK_RESET) ? RESET_VECTOR : IRQ_VECTOR;
        byte_sel = LAST_IDX - idx;
        stack_we = (kind_q != EK_RESET);
    end

    // Bus drive for the current step.
    always_comb begin
        bus_addr  = pc_q;
        bus_we    = 1'b0;
        bus_wdata = 8'h00;
        unique case (state)
            ST_PUSH_PC: begin
                bus_addr  = stk_addr;
                bus_we    = stack_we;
                bus_wdata = pc_push[{byte_sel, 3'b000} +: 8];
            end
            ST_PUSH_ST: begin
                bus_addr  = stk_addr;
                bus_we    = stack_we;
                bus_wdata = st_push;
            end
            ST_VEC:    bus_addr = vec_base + ADDR_W'(idx);
            ST_DUMMY,
            ST_POP_ST,
            ST_POP_PC: bus_addr = stk_addr;
            ST_HOLD:   bus_addr = (kind_q == EK_RETURN) ? stk_addr
                                                        : vec_base + ADDR_W'(LAST_IDX);
            ST_DONE:   bus_addr = pc_acc;
            default:   bus_addr = pc_q;
        endcase
    end

    AST_RESET_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && kind_q == EK_RESET) |-> !bus_we);                      // R6
    AST_WRITE_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (bus_addr >= STACK_BASE && bus_addr <= STACK_TOP));  // R2
    AST_IDLE_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (bus_addr == $past(pc_out)));                          // R9
    AST_NO_WRITE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && kind_q == EK_RETURN) |-> !bus_we);                     // R8

endmodule

// File: tb/exc_sequencer_bench.sv
`timescale 1ns/1ps
module exc_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [31:0] pc_in;
    logic [7:0]  sp_in;
    logic [7:0]  status_in;
    logic [31:0] bus_addr;
    logic        bus_we;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [31:0] pc_out;
    logic [7:0]  sp_out;
    logic [7:0]  status_out;
    logic        done;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0]  stk [256];
    logic [31:0] rst_vec;
    logic [31:0] irq_vec;

    always #2.5 clk = ~clk;

    exc_sequencer u_exc_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .pc_in(pc_in), .sp_in(sp_in), .status_in(status_in),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pc_out(pc_out), .sp_out(sp_out),
        .status_out(status_out), .done(done), .busy(busy)
    );

    function automatic logic [7:0] mem_rd(input logic [31:0] a);
        if (a[31:8] == 24'h000001)      return stk[a[7:0]];
        if (a[31:2] == 30'h3FFF_FFFD)   return rst_vec[{a[1:0], 3'b000} +: 8];
        if (a[31:2] == 30'h3FFF_FFFF)   return irq_vec[{a[1:0], 3'b000} +: 8];
        return a[7:0] ^ a[15:8];
    endfunction

    // Synchronous memory model, one cycle read latency.
    always @(posedge clk) begin
        if (bus_we && bus_addr[31:8] == 24'h000001) stk[bus_addr[7:0]] = bus_wdata;
        bus_rdata <= mem_rd(bus_addr);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] sp_add(input logic [7:0] s, input int d);
        return s + 8'(d);
    endfunction

    task automatic run_seq(input logic [1:0] k, input logic [31:0] pc, input logic [7:0] sp,
                           input logic [7:0] st, input bit poke);
        logic [31:0] ea [11];
        logic        ew [11];
        logic [7:0]  ed [11];
        string       tg [11];
        string       dt [11];
        int          n;
        logic [31:0] pcp, vbase, epc;
        logic [7:0]  stp, esp, est;
        if (k == 2'd3) begin
            n = 8;
            ea[0] = {24'h000001, sp}; ew[0] = 1'b0; tg[0] = "R8 dummy read";
            for (int i = 1; i <= 5; i++) begin
                ea[i] = {24'h000001, sp_add(sp, i)}; ew[i] = 1'b0; tg[i] = "R8 pop";
            end
            ea[6] = ea[5]; ew[6] = 1'b0; tg[6] = "R8 hold";
            est = stk[sp_add(sp, 1)];
            epc = {stk[sp_add(sp, 5)], stk[sp_add(sp, 4)], stk[sp_add(sp, 3)], stk[sp_add(sp, 2)]};
            esp = sp_add(sp, 5);
            ea[7] = epc; ew[7] = 1'b0; tg[7] = "R9 done addr";
        end else begin
            n     = 11;
            pcp   = (k == 2'd1) ? pc + 32'd2 : pc;
            stp   = (k == 2'd1) ? (st | 8'h30) : ((st | 8'h20) & 8'hEF);
            vbase = (k == 2'd0) ? 32'hFFFF_FFF4 : 32'hFFFF_FFFC;
            epc   = (k == 2'd0) ? rst_vec : irq_vec;
            for (int i = 0; i < 4; i++) begin
                ea[i] = {24'h000001, sp_add(sp, -i)}; ew[i] = (k != 2'd0);
                ed[i] = pcp[8*(3-i) +: 8];
                tg[i] = (k == 2'd0) ? "R6 stack read" : "R2 push pc";
                dt[i] = "R4 pushed pc byte";
            end
            ea[4] = {24'h000001, sp_add(sp, -4)}; ew[4] = (k != 2'd0); ed[4] = stp;
            tg[4] = (k == 2'd0) ? "R6 stack read" : "R3 push status"; dt[4] = "R3 status value";
            for (int i = 5; i < 9; i++) begin
                ea[i] = vbase + 32'(i - 5); ew[i] = 1'b0; tg[i] = "R5 vector read";
            end
            ea[9] = vbase + 32'd3; ew[9] = 1'b0; tg[9] = "R5 hold";
            ea[10] = epc; ew[10] = 1'b0; tg[10] = "R9 done addr";
            esp = sp_add(sp, -5);
            est = st | 8'h04;
        end
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; pc_in = pc; sp_in = sp; status_in = st;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < n; c++) begin
            check(tg[c], bus_addr, ea[c]);
            check({tg[c], " we"}, 32'(bus_we), 32'(ew[c]));
            if (ew[c]) check(dt[c], 32'(bus_wdata), 32'(ed[c]));
            check("R9 done pulse", 32'(done), 32'(c == n - 1));
            check("R9 busy", 32'(busy), 32'd1);
            if (c == n - 1) begin
                check((k == 2'd3) ? "R8 pc_out" : "R7 pc_out", pc_out, epc);
                check((k == 2'd3) ? "R8 sp_out" : "R7 sp_out", 32'(sp_out), 32'(esp));
                check((k == 2'd3) ? "R8 status_out" : "R7 status_out", 32'(status_out), 32'(est));
            end
            if (poke && c == 2) begin
                req_valid = 1'b1; req_kind = 2'($urandom);
                pc_in = $urandom; sp_in = 8'($urandom); status_in = 8'($urandom);
            end
            @(negedge clk);
            req_valid = 1'b0;
        end
        check("R9 idle busy", 32'(busy), 32'd0);
        check("R9 idle done", 32'(done), 32'd0);
        check("R9 idle addr", bus_addr, epc);
        if (poke) check("R10 result kept", pc_out, epc);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) stk[i] = 8'($urandom);
        rst_vec = 32'h0000_0200;
        irq_vec = 32'h0000_0300;
        rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0;
        pc_in = '0; sp_in = '0; status_in = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        check("R1 we", 32'(bus_we), 32'd0);
        check("R1 pc_out", pc_out, 32'd0);
        check("R1 sp_out", 32'(sp_out), 32'd0);
        check("R1 status_out", 32'(status_out), 32'd0);
        check("R1 addr", bus_addr, 32'd0);

        // Directed corner cases.
        run_seq(2'd0, 32'h1234_5678, 8'hFF, 8'h00, 1'b0);      // R6 reset entry
        run_seq(2'd1, 32'h0000_0203, 8'hFF, 8'h84, 1'b0);      // R3 break push 0xB4, R4
        run_seq(2'd3, 32'h0000_0300, 8'hFA, 8'h00, 1'b0);      // R8 return to 0x205
        run_seq(2'd2, 32'hABCD_EF01, 8'h02, 8'h10, 1'b0);      // R2 page wrap downward
        run_seq(2'd3, 32'h0, 8'hFD, 8'h00, 1'b0);              // R8 page wrap upward
        run_seq(2'd1, 32'hFFFF_FFFF, 8'h80, 8'h00, 1'b1);      // R10 ignored request, R4 wrap

        // Constrained random mix.
        for (int t = 0; t < 60; t++) begin
            rst_vec = $urandom;
            irq_vec = $urandom;
            run_seq(2'($urandom), $urandom, 8'($urandom), 8'($urandom), ($urandom % 4) == 0);
        end

        // R1 reset in the middle of a sequence.
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd2; pc_in = 32'h55; sp_in = 8'h40; status_in = 8'h0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid reset busy", 32'(busy), 32'd0);
        check("R1 mid reset we", 32'(bus_we), 32'd0);
        check("R1 mid reset pc", pc_out, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule